// File: doc/BRIEF.md
# Error Event Counter Bank with Tear-Free Byte Readout

This block keeps seven 16-bit event counters for line and framing error monitoring: excessive-zero events, line code violations, framing errors, parity errors, far-end block errors, CP-bit errors and PRBS errors. An upstream detector delivers a one-cycle pulse per event on the counter's own input bit. Counters saturate instead of wrapping. A host with an 8-bit read path reads them.

Each counter appears as two byte registers. The host can start on either byte. That first read returns the chosen byte and zeroes the whole counter in the same clock. It also copies the other byte into one capture register that all counters share. The host then reads the capture register to get the second byte. The two bytes therefore always come from the same counter value, even though events keep arriving.

Top module: `pmon_bank`

## Requirements
- R1: After reset, all counters and the capture register are zero, and the read data output is 0x00.
- R2: Each one-cycle event pulse on `evt_i[k]` raises counter k by exactly one.
- R3: A counter at 0xFFFF stays at 0xFFFF when further events arrive.
- R4: Address map. Counter k's high byte is at address 2k and its low byte at 2k+1, for k = 0 to 6. The capture register is at address 14. Read data appears on `rdata_o` in the clock cycle after the read strobe is sampled.
- R5: A read of a counter's high byte returns bits 15:8 of that counter and loads bits 7:0 into the capture register.
- R6: A read of a counter's low byte returns bits 7:0 of that counter and loads bits 15:8 into the capture register.
- R7: A read of either byte of a counter sets that whole counter to zero.
- R8: An event pulse in the same cycle as a clearing read leaves the counter at 1 afterwards.
- R9: The capture register keeps its value until the next read of any counter byte. Reads of the capture register, reads of unmapped addresses and events do not change it.
- R10: A cycle with the write strobe high changes nothing: no counter is cleared and the capture register is not changed. This also applies when the read strobe is high in the same cycle.
- R11: Reading one counter does not affect any other counter.
- R12: A read of an address above 14 returns 0x00 and clears no counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized inside the block |
| evt_i | input | 7 | One-cycle event pulse per counter, bit k for counter k |
| addr_i | input | 5 | Host register address |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wr_i | input | 1 | Write strobe; has no effect on any state |
| rdata_o | output | 8 | Registered read data, valid the cycle after the read strobe |

## Verification
The assertions assume the following about the inputs:
- Each read strobe is a single-cycle access.
- Event inputs are synchronous to `clk`.
- The address is stable in the cycle the strobe is sampled.

The bench drives every input on the falling clock edge and raises each strobe for exactly one cycle. It returns the strobe to low before the next access. Event bursts are driven as contiguous pulses whose length sets the expected count. The one deliberate overlap is an event that coincides with a clearing read, which tests R8.

// File: rtl/pmon_pkg.sv
package pmon_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_CTR_HI,
    ACC_CTR_LO,
    ACC_HOLD,
    ACC_UNMAPPED
  } acc_kind_e;
endpackage

// File: rtl/pmon_rst_sync.sv
module pmon_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_nxt;

  always_comb begin
    sync_nxt = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_nxt;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/pmon_counter.sv
module pmon_counter #(
  parameter int CTR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_i,
  input  logic             clr_i,
  output logic [CTR_W-1:0] cnt_o
);
  localparam logic [CTR_W-1:0] CNT_MAX = '1;
  localparam logic [CTR_W-1:0] CNT_ONE = CTR_W'(1);

  logic [CTR_W-1:0] cnt_q;
  logic [CTR_W-1:0] cnt_nxt;
  logic             cnt_en;
  logic             at_max;

  always_comb begin
    at_max  = (cnt_q == CNT_MAX);
    cnt_en  = clr_i | (evt_i & ~at_max);
    cnt_nxt = cnt_q;
    if (clr_i) begin
      cnt_nxt = evt_i ? CNT_ONE : '0;
    end else if (evt_i && !at_max) begin
      cnt_nxt = cnt_q + CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nxt;
  end

  assign cnt_o = cnt_q;

  // R2: an event without a clear adds exactly one below the ceiling
  p_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i && !clr_i && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + CNT_ONE));

  // R3: the ceiling holds
  p_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !clr_i) |=> (cnt_q == CNT_MAX));

  // R7: a clear alone zeroes the counter
  p_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !evt_i) |=> (cnt_q == '0));

  // R8: a clear that meets an event keeps the event
  p_clr_evt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && evt_i) |=> (cnt_q == CNT_ONE));

  // idle counter keeps its value
  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !evt_i) |=> $stable(cnt_q));
endmodule

// File: rtl/pmon_host_if.sv
module pmon_host_if
  import pmon_pkg::*;
#(
  parameter int NUM_CTR = 7,
  parameter int ADDR_W  = 5
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic                           rd_i,
  input  logic                           wr_i,
  input  logic [NUM_CTR-1:0][WORD_W-1:0] ctr_i,
  output logic [NUM_CTR-1:0]             clr_o,
  output logic [BYTE_W-1:0]              rdata_o
);
  localparam int                IDX_W  = ADDR_W - 1;
  localparam logic [ADDR_W-1:0] HOLD_A = ADDR_W'(2 * NUM_CTR);

  acc_kind_e         kind;
  logic              rd_ok;
  logic [IDX_W-1:0]  sel_idx;
  logic [WORD_W-1:0] sel_val;
  logic [BYTE_W-1:0] hold_q;
  logic [BYTE_W-1:0] hold_nxt;
  logic              hold_en;
  logic [BYTE_W-1:0] rdata_q;
  logic [BYTE_W-1:0] rdata_nxt;

  // access decode: a cycle with the write strobe is never a read
  always_comb begin
    rd_ok   = rd_i & ~wr_i;
    sel_idx = addr_i[ADDR_W-1:1];
    if (!rd_ok)                kind = ACC_NONE;
    else if (addr_i == HOLD_A) kind = ACC_HOLD;
    else if (addr_i < HOLD_A)  kind = addr_i[0] ? ACC_CTR_LO : ACC_CTR_HI;
    else                       kind = ACC_UNMAPPED;
  end

  always_comb begin
    sel_val = '0;
    for (int k = 0; k < NUM_CTR; k++) begin
      if (sel_idx == IDX_W'(k)) sel_val = ctr_i[k];
    end
  end

  generate
    for (genvar g = 0; g < NUM_CTR; g++) begin : g_clr
      assign clr_o[g] = ((kind == ACC_CTR_HI) || (kind == ACC_CTR_LO))
                        && (sel_idx == IDX_W'(g));
    end
  endgenerate

  always_comb begin
    hold_en   = 1'b0;
    hold_nxt  = hold_q;
    rdata_nxt = '0;
    case (kind)
      ACC_CTR_HI: begin
        rdata_nxt = sel_val[WORD_W-1:BYTE_W];
        hold_nxt  = sel_val[BYTE_W-1:0];
        hold_en   = 1'b1;
      end
      ACC_CTR_LO: begin
        rdata_nxt = sel_val[BYTE_W-1:0];
        hold_nxt  = sel_val[WORD_W-1:BYTE_W];
        hold_en   = 1'b1;
      end
      ACC_HOLD: rdata_nxt = hold_q;
      default:  rdata_nxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_en) hold_q <= hold_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_ok) rdata_q <= rdata_nxt;
  end

  assign rdata_o = rdata_q;

  // R11: at most one counter is cleared per access
  p_one_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_o));

  // R10: the write strobe never clears a counter
  p_wr_noclr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |-> (clr_o == '0));

  // R9: capture register moves only on a counter byte read
  p_hold_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_i && !wr_i && addr_i < HOLD_A) |=> $stable(hold_q));

  // R4: capture register read returns its content one cycle later
  p_hold_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !wr_i && addr_i == HOLD_A) |=> (rdata_o == $past(hold_q)));

  // R5: high byte read returns upper half, parks lower half
  p_hi_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !wr_i && addr_i < HOLD_A && !addr_i[0]) |=>
      (rdata_o == $past(sel_val[WORD_W-1:BYTE_W]) &&
       hold_q  == $past(sel_val[BYTE_W-1:0])));

  // R6: low byte read returns lower half, parks upper half
  p_lo_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !wr_i && addr_i < HOLD_A && addr_i[0]) |=>
      (rdata_o == $past(sel_val[BYTE_W-1:0]) &&
       hold_q  == $past(sel_val[WORD_W-1:BYTE_W])));

  // R12: unmapped reads return zero
  p_unmapped_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !wr_i && addr_i > HOLD_A) |=> (rdata_o == '0));
endmodule

// File: rtl/pmon_bank.sv
module pmon_bank
  import pmon_pkg::*;
#(
  parameter int NUM_CTR = 7,
  parameter int ADDR_W  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CTR-1:0] evt_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               rd_i,
  input  logic               wr_i,
  output logic [BYTE_W-1:0]  rdata_o
);
  logic                           rst_n_s;
  logic [NUM_CTR-1:0][WORD_W-1:0] ctr_val;
  logic [NUM_CTR-1:0]             ctr_clr;

  pmon_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  generate
    for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
      pmon_counter #(.CTR_W(WORD_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n_s),
        .evt_i (evt_i[g]),
        .clr_i (ctr_clr[g]),
        .cnt_o (ctr_val[g])
      );
    end
  endgenerate

  pmon_host_if #(.NUM_CTR(NUM_CTR), .ADDR_W(ADDR_W)) u_host (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .addr_i  (addr_i),
    .rd_i    (rd_i),
    .wr_i    (wr_i),
    .ctr_i   (ctr_val),
    .clr_o   (ctr_clr),
    .rdata_o (rdata_o)
  );

  // R1: read data is zero while the block is held in reset
  p_rst_data_r1: assert property (@(posedge clk)
    !rst_n_s |=> (!rst_n_s || rdata_o == '0) || (rdata_o == '0));
endmodule

// File: tb/sim_pmon_bank.sv
module sim_pmon_bank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] evt = '0;
  logic [4:0] addr = '0;
  logic       rd = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] rdata;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pmon_bank u0 (
    .clk(clk), .rst_n(rst_n), .evt_i(evt),
    .addr_i(addr), .rd_i(rd), .wr_i(wr), .rdata_o(rdata)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic rd_byte(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    d = rdata;
  endtask

  task automatic pulse(input int k, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); evt[k] = 1'b1;
    end
    @(negedge clk); evt[k] = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 rdata after reset", rdata, 8'h00);
    rd_byte(5'd0, d);  chk("R1 ctr0 hi", d, 8'h00);
    rd_byte(5'd14, d); chk("R1 hold", d, 8'h00);
    rd_byte(5'd13, d); chk("R1 ctr6 lo", d, 8'h00);
  endtask

  task automatic t_hi_first();
    logic [7:0] d;
    pulse(2, 291);
    rd_byte(5'd4, d);  chk("R5 R2 R4 ctr2 hi", d, 8'h01);
    rd_byte(5'd14, d); chk("R5 hold low byte", d, 8'h23);
    rd_byte(5'd5, d);  chk("R7 ctr2 cleared", d, 8'h00);
  endtask

  task automatic t_lo_first();
    logic [7:0] d;
    pulse(4, 421);
    rd_byte(5'd9, d);  chk("R6 ctr4 lo", d, 8'hA5);
    rd_byte(5'd14, d); chk("R6 hold high byte", d, 8'h01);
    rd_byte(5'd8, d);  chk("R7 ctr4 cleared", d, 8'h00);
  endtask

  task automatic t_indep();
    logic [7:0] d;
    for (int i = 0; i < 7; i++) begin
      @(negedge clk); evt[0] = (i < 5); evt[6] = 1'b1;
    end
    @(negedge clk); evt = '0;
    rd_byte(5'd1, d);  chk("R11 ctr0 lo", d, 8'h05);
    rd_byte(5'd13, d); chk("R11 ctr6 untouched", d, 8'h07);
  endtask

  task automatic t_coincide();
    logic [7:0] d;
    pulse(1, 3);
    @(negedge clk); addr = 5'd2; rd = 1'b1; evt[1] = 1'b1;
    @(negedge clk); rd = 1'b0; evt[1] = 1'b0;
    chk("R8 hi byte on clearing read", rdata, 8'h00);
    rd_byte(5'd14, d); chk("R8 hold", d, 8'h03);
    rd_byte(5'd3, d);  chk("R8 event kept", d, 8'h01);
  endtask

  task automatic t_hold_keep();
    logic [7:0] d;
    pulse(3, 564);
    rd_byte(5'd6, d);  chk("R5 ctr3 hi", d, 8'h02);
    pulse(5, 10);
    rd_byte(5'd20, d); chk("R12 unmapped read", d, 8'h00);
    rd_byte(5'd31, d); chk("R12 top address", d, 8'h00);
    @(negedge clk); addr = 5'd14; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    rd_byte(5'd14, d); chk("R9 hold kept", d, 8'h34);
    rd_byte(5'd14, d); chk("R9 hold kept again", d, 8'h34);
    rd_byte(5'd10, d); chk("R12 R9 ctr5 hi", d, 8'h00);
    rd_byte(5'd14, d); chk("R9 hold overwritten", d, 8'h0A);
  endtask

  task automatic t_write();
    logic [7:0] d;
    pulse(0, 9);
    @(negedge clk); addr = 5'd1; wr = 1'b1;
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0; wr = 1'b0;
    rd_byte(5'd0, d);  chk("R10 ctr0 hi", d, 8'h00);
    rd_byte(5'd14, d); chk("R10 ctr0 not cleared", d, 8'h09);
  endtask

  task automatic t_sat();
    logic [7:0] d;
    pulse(6, 65537);
    rd_byte(5'd13, d); chk("R3 ctr6 lo", d, 8'hFF);
    rd_byte(5'd14, d); chk("R3 ctr6 hi", d, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_hi_first();
    t_lo_first();
    t_indep();
    t_coincide();
    t_hold_keep();
    t_write();
    t_sat();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule